// File: doc/BRIEF.md
# Banked Program Address Sequencer

This block produces the 13-bit program memory address for a small 8-bit controller core. The core's own program counter spans only 4K. A single bit, driven from an output port, chooses which 4K half of an 8K program store is in use. The sequencer holds four pieces of state: the 12-bit program counter, a pending bank flag, the half-select bit and an eight-entry return stack. It is driven by decoded control strobes from the instruction decoder and presents the address for the next fetch.

Within a 4K half there are two 2K banks. Selecting a bank only records a pending flag. That flag becomes address bit 11 on the next jump or call, so ordinary sequential fetches are not affected by it. The half-select bit works differently. A port write that changes it moves execution immediately: the next fetch comes from the next sequential address in the other half. Stacked return addresses, including their bank bit, stay in force after such a switch and are applied inside whichever half is selected when the return executes. A page-table read uses one extra cycle to put a data address on the same bus and leaves the program counter untouched.

Top module: `prog_addr_seq`

## Requirements
- R1: Directly after reset the fetch address is 0x1000 (half-select bit high, counter zero), `page_rd` is 0, the bank flag is 0 and the stack is empty.
- R2: Each `op_next` advances the counter by one within its low 11 bits. Bit 11 is never carried into, so 0x7FF is followed by 0x000 and 0xFFF is followed by 0x800.
- R3: `op_sel` with `sel_val` only stores the bank flag. The fetch address after that cycle is the same as it would be without the strobe.
- R4: `op_jump` loads the counter with the bank flag as bit 11 and `target` as bits 10:0. The half-select bit is unchanged.
- R5: `op_call` pushes the counter's sequential successor (12 bits, bank bit included) and loads the counter the way a jump does. `op_ret` pops the most recent entry into the counter.
- R6: `port_wr` copies bit 6 of `port_data` into the half-select bit, which is fetch address bit 12. When it occurs together with `op_next`, the next fetch is the next sequential address in the newly selected half.
- R7: Changing the half-select bit keeps the bank flag and the stack contents. A return after a change restores the stacked 12 bits under the half-select bit that is current at the time of the return.
- R8: `op_page` makes the next cycle a data read. In that cycle `page_rd` is 1 and the fetch address is {half bit, counter bits 11:8, `acc`}. In the cycle after, the counter is the same as before the read.
- R9: With `page3` high, `op_page` forces address bits 11:8 of the data read to 0x3.
- R10: The stack holds 8 entries and wraps. After nine calls, the first return yields the ninth return address, the eighth yields the second, and the ninth yields the ninth again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_next | input | 1 | Advance to the next sequential instruction |
| op_jump | input | 1 | Jump to `target` within the current half |
| op_call | input | 1 | Push return address, then jump to `target` |
| op_ret | input | 1 | Pop return address into the counter |
| op_page | input | 1 | Start a one-cycle page-table data read |
| page3 | input | 1 | Page-table read forced to page 3 |
| acc | input | 8 | Low address byte for a page-table read |
| target | input | 11 | Jump or call destination within a bank |
| op_sel | input | 1 | Store `sel_val` in the bank flag |
| sel_val | input | 1 | New bank flag value |
| port_wr | input | 1 | Output port written this cycle |
| port_data | input | 8 | Port value; bit 6 is the half-select bit |
| fetch_addr | output | 13 | Program memory address |
| page_rd | output | 1 | Current address is a page-table data read |

## Verification
The assertions assume that `op_next`, `op_jump`, `op_call`, `op_ret` and `op_page` are never active together, and that no strobe arrives during the data-read cycle that follows `op_page`. They also assume that a port write never coincides with `op_page`. The directed stimulus drives at most one of these strobes per cycle and always leaves the read cycle idle. It combines `op_sel` and `port_wr` only with sequential, jump, call or idle cycles, so every checked situation stays inside those assumptions.

// File: rtl/prog_addr_seq.sv
module prog_addr_seq #(
  parameter int PC_W      = 12,
  parameter int STK_DEPTH = 8,
  parameter int ACC_W     = 8,
  parameter int PORT_W    = 8,
  parameter int HALF_BIT  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_next,
  input  logic                op_jump,
  input  logic                op_call,
  input  logic                op_ret,
  input  logic                op_page,
  input  logic                page3,
  input  logic [ACC_W-1:0]    acc,
  input  logic [PC_W-2:0]     target,
  input  logic                op_sel,
  input  logic                sel_val,
  input  logic                port_wr,
  input  logic [PORT_W-1:0]   port_data,
  output logic [PC_W:0]       fetch_addr,
  output logic                page_rd
);
  localparam int BANK_BIT = PC_W - 1;
  localparam int PAGE_W   = PC_W - ACC_W;
  localparam int SP_W     = $clog2(STK_DEPTH);

  logic [PC_W-1:0] pc, rd_addr;
  logic            half, bank, rd_pend;
  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] stk [STK_DEPTH];

  wire [PC_W-1:0] pc_inc = {pc[BANK_BIT], pc[BANK_BIT-1:0] + 1'b1};
  wire [PC_W-1:0] pc_tgt = {bank, target};
  wire [SP_W-1:0] sp_top = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      half    <= 1'b1;
      bank    <= 1'b0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      sp      <= '0;
    end else begin
      rd_pend <= op_page;
      if (op_page)
        rd_addr <= {page3 ? PAGE_W'(3) : pc[PC_W-1:ACC_W], acc};
      if (op_sel)  bank <= sel_val;
      if (port_wr) half <= port_data[HALF_BIT];
      if (op_next)
        pc <= pc_inc;
      else if (op_jump)
        pc <= pc_tgt;
      else if (op_call) begin
        pc <= pc_tgt;
        sp <= sp + 1'b1;
      end else if (op_ret) begin
        pc <= stk[sp_top];
        sp <= sp_top;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && op_call && !op_next && !op_jump) stk[sp] <= pc_inc;

  assign fetch_addr = {half, rd_pend ? rd_addr : pc};
  assign page_rd    = rd_pend;

  assert_ops_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_next, op_jump, op_call, op_ret, op_page}));

  assert_read_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_rd |-> !(op_next || op_jump || op_call || op_ret || op_page));

  assert_seq_keeps_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_next && !port_wr) |=> fetch_addr[PC_W:BANK_BIT] == $past(fetch_addr[PC_W:BANK_BIT]));

  assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_jump || op_call) |=> fetch_addr[BANK_BIT-1:0] == $past(target));

  assert_half_follows_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !op_page) |=> fetch_addr[PC_W] == $past(port_data[HALF_BIT]));

  assert_ret_keeps_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ret && !port_wr) |=> $stable(fetch_addr[PC_W]));

  assert_page_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_page |=> page_rd && fetch_addr[ACC_W-1:0] == $past(acc));

  assert_page3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_page && page3) |=> fetch_addr[PC_W-1:ACC_W] == PAGE_W'(3));
endmodule

// File: tb/prog_addr_seq_bench.sv
module prog_addr_seq_bench;
  logic clk = 0, rst_n = 0;
  logic op_next = 0, op_jump = 0, op_call = 0, op_ret = 0, op_page = 0, page3 = 0;
  logic [7:0] acc = 0;
  logic [10:0] target = 0;
  logic op_sel = 0, sel_val = 0, port_wr = 0;
  logic [7:0] port_data = 0;
  logic [12:0] fetch_addr;
  logic page_rd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prog_addr_seq u_prog_addr_seq (.*);

  task automatic chk(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    op_next = 0; op_jump = 0; op_call = 0; op_ret = 0; op_page = 0; page3 = 0;
    op_sel = 0; port_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 addr", fetch_addr, 13'h1000);
    chk("R1 page_rd", {12'h0, page_rd}, 13'h0);
  endtask

  task automatic t_seq_bank();
    do_reset();
    for (int i = 0; i < 3; i++) begin op_next = 1; tick(); end
    chk("R2 step", fetch_addr, 13'h1003);
    op_jump = 1; target = 11'h7FE; tick();
    chk("R4 jump bank0", fetch_addr, 13'h17FE);
    op_next = 1; tick(); op_next = 1; tick();
    chk("R2 wrap low bank", fetch_addr, 13'h1000);
    op_sel = 1; sel_val = 1; op_next = 1; tick();
    chk("R3 sel no effect", fetch_addr, 13'h1001);
    op_next = 1; tick();
    chk("R3 sel still pending", fetch_addr, 13'h1002);
    op_jump = 1; target = 11'h7FF; tick();
    chk("R4 jump bank1", fetch_addr, 13'h1FFF);
    op_next = 1; tick();
    chk("R2 wrap high bank", fetch_addr, 13'h1800);
  endtask

  task automatic t_port();
    port_wr = 1; port_data = 8'hBF; op_next = 1; tick();
    chk("R6 clear half", fetch_addr, 13'h0801);
    port_wr = 1; port_data = 8'h40; op_next = 1; tick();
    chk("R6 set half", fetch_addr, 13'h1802);
  endtask

  task automatic t_call_half();
    do_reset();
    op_sel = 1; sel_val = 1; tick();
    chk("R3 sel idle", fetch_addr, 13'h1000);
    op_sel = 1; sel_val = 0; op_call = 1; target = 11'h123; tick();
    chk("R5 call", fetch_addr, 13'h1923);
    op_ret = 1; tick();
    chk("R5 ret", fetch_addr, 13'h1001);
    op_sel = 1; sel_val = 1; tick();
    op_jump = 1; target = 11'h010; tick();
    chk("R4 jump", fetch_addr, 13'h1810);
    op_call = 1; target = 11'h200; tick();
    chk("R5 call bank1", fetch_addr, 13'h1A00);
    port_wr = 1; port_data = 8'h00; op_next = 1; tick();
    chk("R6 leave upper", fetch_addr, 13'h0A01);
    op_ret = 1; tick();
    chk("R7 ret other half", fetch_addr, 13'h0811);
    op_jump = 1; target = 11'h005; tick();
    chk("R7 bank kept", fetch_addr, 13'h0805);
  endtask

  task automatic t_page();
    do_reset();
    op_jump = 1; target = 11'h2A5; tick();
    op_page = 1; acc = 8'h3C; tick();
    chk("R8 read addr", fetch_addr, 13'h123C);
    chk("R8 page_rd", {12'h0, page_rd}, 13'h1);
    tick();
    chk("R8 pc kept", fetch_addr, 13'h12A5);
    chk("R8 page_rd low", {12'h0, page_rd}, 13'h0);
    op_page = 1; page3 = 1; acc = 8'h77; tick();
    chk("R9 page3", fetch_addr, 13'h1377);
    tick();
    chk("R9 pc kept", fetch_addr, 13'h12A5);
  endtask

  task automatic t_stack();
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      op_call = 1; target = 11'(k * 16); tick();
    end
    chk("R10 ninth call", fetch_addr, 13'h1090);
    op_ret = 1; tick();
    chk("R10 pop1", fetch_addr, 13'h1081);
    for (int k = 2; k <= 8; k++) begin op_ret = 1; tick(); end
    chk("R10 pop8", fetch_addr, 13'h1011);
    op_ret = 1; tick();
    chk("R10 pop9 wrap", fetch_addr, 13'h1081);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_seq_bank();
    t_port();
    t_call_half();
    t_page();
    t_stack();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule